// File: doc/BRIEF.md
# Conversion-Complete Event Router

This block takes the "conversion complete" strobe of one analog channel and delivers it to the right consumer. There are three. A CPU interrupt request comes from a sticky event flag and an enable bit. A request pulse goes to an intelligent DMA engine; when that path is armed, the interrupt path is bypassed. Trigger pulses go to any of four high-speed DMA channels, each channel with its own 4-bit trigger selector.

When the intelligent-DMA path is armed, the event does not set the flag. The engine's completion pulse sets it, and only if completion interrupts are allowed. A small combinational check tells the interrupt arbiter whether the CPU would take the request, given its global interrupt-enable bit, its current level and any pending higher-priority request.

Software reaches the block through a byte-wide write/read port. Register 0 holds the flag in bit 0 (write 1 to clear), the interrupt enable in bit 1 and the priority in bits 6:4. Register 1 holds the DMA request bit in bit 0, the DMA enable in bit 1 and the completion-interrupt allow bit in bit 2. Register 2 holds the selectors of channels 0 and 1, in bits 3:0 and 7:4. Register 3 holds the selectors of channels 2 and 3 in the same layout.

Top module: `evt_router`

## Requirements
- R1: After synchronous reset, all four registers read 0 and `irq_req`, `cpu_accept`, `idma_req` and `hs_trig` are all low.
- R2: When the DMA path is not armed, a rising edge on `evt_done` sets the flag (register 0 bit 0) at the next clock edge, whatever the interrupt enable is.
- R3: `irq_req` is high exactly while the flag and the interrupt enable (register 0 bit 1) are both 1. It falls as soon as the enable write takes effect.
- R4: Writing register 0 with bit 0 set clears the flag, and writing bit 0 as 0 leaves it unchanged. If an event and a clear occur in the same cycle, the flag ends up set.
- R5: The priority is the 3-bit field in register 0 bits 6:4. It reads back and appears on `irq_level` for all values 0 to 7.
- R6: `cpu_accept` is 1 only when `irq_req`, `cpu_ie` and the absence of `hi_pend` all hold and `cpu_il` is strictly less than the priority.
- R7: With register 1 bits 0 and 1 both set, an event edge gives a one-cycle `idma_req` pulse on the next cycle, with `idma_chan` = 0x1B, and the flag is left clear. With only one of those bits set, the event takes the interrupt path.
- R8: A `dma_done` pulse sets the flag when register 1 bit 2 is 1, and has no effect when it is 0.
- R9: `hs_trig[i]` pulses for one cycle, the cycle after an event edge, exactly when selector i equals 4'b1100, independent of the interrupt and DMA settings.
- R10: An `evt_done` held high for several cycles produces only one pulse on each DMA output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_done | input | 1 | Conversion-complete strobe, acted on at its rising edge |
| dma_done | input | 1 | One-cycle completion pulse from the intelligent DMA engine |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register index |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| cpu_ie | input | 1 | CPU global interrupt enable |
| cpu_il | input | 3 | CPU current interrupt level |
| hi_pend | input | 1 | A higher-priority request is pending |
| irq_req | output | 1 | Interrupt request |
| irq_level | output | 3 | Programmed priority |
| cpu_accept | output | 1 | The CPU would take this request now |
| idma_req | output | 1 | Intelligent DMA request pulse |
| idma_chan | output | 5 | Intelligent DMA channel number (0x1B) |
| hs_trig | output | 4 | High-speed DMA trigger pulses, one per channel |

## Verification
The acceptance check is swept over every combination of priority, CPU level, CPU enable and pending flag. This separates a strict compare from a less-or-equal compare and shows that each blocking input is honoured on its own. Every one of the 16 trigger codes is placed in each selector with the channels staggered. This exposes a wrong match code or a wrong nibble-to-channel mapping, and a repeat with the DMA path armed shows the triggers do not depend on it. The two DMA arming bits are tried alone and together, and the completion pulse is tried with and without its allow bit. Same-cycle event-and-clear and a held event level separate "event wins" from "clear wins", and edge detection from level detection.

// File: rtl/evt_router_pkg.sv
package evt_router_pkg;
    localparam int DW        = 8;
    localparam int AW        = 2;
    localparam int PRIO_W    = 3;
    localparam int SEL_W     = 4;
    localparam int N_HS      = 4;
    localparam int CH_W      = 5;
    localparam logic [SEL_W-1:0] TRIG_CODE = 4'b1100;
    localparam logic [CH_W-1:0]  IDMA_CH   = 5'h1B;
    localparam int SEL_PER_WORD = DW / SEL_W;

    typedef enum logic [AW-1:0] {
        A_IRQ  = 2'd0,
        A_DMA  = 2'd1,
        A_HS01 = 2'd2,
        A_HS23 = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic                            irq_en;
        logic [PRIO_W-1:0]               prio;
        logic                            idma_rq;
        logic                            idma_en;
        logic                            done_irq_en;
        logic [N_HS-1:0][SEL_W-1:0]      hs_sel;
    } cfg_t;

    function automatic logic sel_hit(input logic [SEL_W-1:0] sel);
        return sel == TRIG_CODE;
    endfunction

    function automatic logic [AW-1:0] hs_word(input int ch);
        return AW'(int'(A_HS01) + ch / SEL_PER_WORD);
    endfunction
endpackage

// File: rtl/evt_router_regs.sv
module evt_router_regs
    import evt_router_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          evt_rise,
    input  logic          dma_done,
    output cfg_t          cfg,
    output logic          flag,
    output logic [DW-1:0] rdata
);
    logic flag_set, flag_clr, idma_mode;

    assign idma_mode = cfg.idma_rq & cfg.idma_en;
    assign flag_set  = (evt_rise & ~idma_mode) | (dma_done & cfg.done_irq_en);
    assign flag_clr  = we & (addr == A_IRQ) & wdata[0];

    always_ff @(posedge clk) begin
        if (rst)           flag <= 1'b0;
        else if (flag_set) flag <= 1'b1;
        else if (flag_clr) flag <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.irq_en      <= 1'b0;
            cfg.prio        <= '0;
            cfg.idma_rq     <= 1'b0;
            cfg.idma_en     <= 1'b0;
            cfg.done_irq_en <= 1'b0;
        end else if (we && addr == A_IRQ) begin
            cfg.irq_en <= wdata[1];
            cfg.prio   <= wdata[4 +: PRIO_W];
        end else if (we && addr == A_DMA) begin
            cfg.idma_rq     <= wdata[0];
            cfg.idma_en     <= wdata[1];
            cfg.done_irq_en <= wdata[2];
        end
    end

    for (genvar i = 0; i < N_HS; i++) begin : g_sel
        localparam logic [AW-1:0] WA  = hs_word(i);
        localparam int            LSB = (i % SEL_PER_WORD) * SEL_W;
        always_ff @(posedge clk) begin
            if (rst)                   cfg.hs_sel[i] <= '0;
            else if (we && addr == WA) cfg.hs_sel[i] <= wdata[LSB +: SEL_W];
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_IRQ: begin
                rdata[0]            = flag;
                rdata[1]            = cfg.irq_en;
                rdata[4 +: PRIO_W]  = cfg.prio;
            end
            A_DMA:  rdata[2:0] = {cfg.done_irq_en, cfg.idma_en, cfg.idma_rq};
            A_HS01: rdata = {cfg.hs_sel[1], cfg.hs_sel[0]};
            default: rdata = {cfg.hs_sel[3], cfg.hs_sel[2]};
        endcase
    end

    // R2: an event outside DMA mode leaves the flag set
    a_r2_evt_sets_flag: assert property (@(posedge clk) disable iff (rst)
        (evt_rise && !idma_mode) |=> flag);
    // R4: a lone clear empties the flag
    a_r4_clear_alone: assert property (@(posedge clk) disable iff (rst)
        (flag_clr && !flag_set) |=> !flag);
    // R8: completion with allow bit set raises the flag
    a_r8_done_sets: assert property (@(posedge clk) disable iff (rst)
        (dma_done && cfg.done_irq_en) |=> flag);
endmodule

// File: rtl/evt_router_hs_bank.sv
module evt_router_hs_bank
    import evt_router_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       evt_rise,
    input  logic [N_HS-1:0][SEL_W-1:0] sel,
    output logic [N_HS-1:0]            trig
);
    for (genvar i = 0; i < N_HS; i++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst) trig[i] <= 1'b0;
            else     trig[i] <= evt_rise & sel_hit(sel[i]);
        end

        // R10: never two pulses back to back
        a_r10_hs_single: assert property (@(posedge clk) disable iff (rst)
            trig[i] |=> !trig[i]);
        // R9: a pulse always follows an event edge
        a_r9_hs_after_evt: assert property (@(posedge clk) disable iff (rst)
            trig[i] |-> $past(evt_rise));
    end
endmodule

// File: rtl/evt_router_accept.sv
module evt_router_accept
    import evt_router_pkg::*;
(
    input  logic              irq_req,
    input  logic [PRIO_W-1:0] prio,
    input  logic              cpu_ie,
    input  logic [PRIO_W-1:0] cpu_il,
    input  logic              hi_pend,
    output logic              accept
);
    always_comb accept = irq_req & cpu_ie & ~hi_pend & (cpu_il < prio);
endmodule

// File: rtl/evt_router.sv
module evt_router
    import evt_router_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              evt_done,
    input  logic              dma_done,
    input  logic              bus_we,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic              cpu_ie,
    input  logic [PRIO_W-1:0] cpu_il,
    input  logic              hi_pend,
    output logic              irq_req,
    output logic [PRIO_W-1:0] irq_level,
    output logic              cpu_accept,
    output logic              idma_req,
    output logic [CH_W-1:0]   idma_chan,
    output logic [N_HS-1:0]   hs_trig
);
    cfg_t cfg;
    logic flag, evt_q, evt_rise;

    always_ff @(posedge clk) begin
        if (rst) evt_q <= 1'b0;
        else     evt_q <= evt_done;
    end
    assign evt_rise = evt_done & ~evt_q;

    evt_router_regs u_regs (
        .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
        .evt_rise(evt_rise), .dma_done(dma_done),
        .cfg(cfg), .flag(flag), .rdata(bus_rdata)
    );

    evt_router_hs_bank u_hs (
        .clk(clk), .rst(rst), .evt_rise(evt_rise), .sel(cfg.hs_sel), .trig(hs_trig)
    );

    always_ff @(posedge clk) begin
        if (rst) idma_req <= 1'b0;
        else     idma_req <= evt_rise & cfg.idma_rq & cfg.idma_en;
    end

    assign idma_chan = IDMA_CH;
    assign irq_req   = flag & cfg.irq_en;
    assign irq_level = cfg.prio;

    evt_router_accept u_acc (
        .irq_req(irq_req), .prio(cfg.prio), .cpu_ie(cpu_ie), .cpu_il(cpu_il),
        .hi_pend(hi_pend), .accept(cpu_accept)
    );

    // R6: the CPU level must sit strictly below the request level
    a_r6_level_below: assert property (@(posedge clk) disable iff (rst)
        cpu_accept |-> (cpu_il < irq_level) && cpu_ie && !hi_pend);
    // R7: DMA request lasts one cycle
    a_r7_idma_one_cycle: assert property (@(posedge clk) disable iff (rst)
        idma_req |=> !idma_req);
    // R7: a DMA-routed event does not raise the flag by itself
    a_r7_idma_no_flag: assert property (@(posedge clk) disable iff (rst)
        (idma_req && !$past(flag) && !$past(dma_done) && !$past(rst)) |-> !flag);
endmodule

// File: tb/sim_evt_router.sv
module sim_evt_router;
    logic       clk = 1'b0;
    logic       rst, evt_done, dma_done, bus_we, cpu_ie, hi_pend;
    logic [1:0] bus_addr;
    logic [7:0] bus_wdata, bus_rdata;
    logic [2:0] cpu_il, irq_level;
    logic       irq_req, cpu_accept, idma_req;
    logic [4:0] idma_chan;
    logic [3:0] hs_trig;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    evt_router u0 (
        .clk(clk), .rst(rst), .evt_done(evt_done), .dma_done(dma_done),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .cpu_ie(cpu_ie), .cpu_il(cpu_il),
        .hi_pend(hi_pend), .irq_req(irq_req), .irq_level(irq_level),
        .cpu_accept(cpu_accept), .idma_req(idma_req), .idma_chan(idma_chan),
        .hs_trig(hs_trig)
    );

    task automatic step();
        @(posedge clk);
        #1.5;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_we = 1'b0; bus_wdata = 8'h00;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic fire();
        evt_done = 1'b1;
        step();
        evt_done = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        rst = 1'b1; evt_done = 0; dma_done = 0; bus_we = 0; bus_addr = 0;
        bus_wdata = 0; cpu_ie = 0; cpu_il = 0; hi_pend = 0;
        step(); step();
        rst = 1'b0;
        step();

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), d);
            chk("R1 reg", d, 0);
        end
        chk("R1 irq_req", irq_req, 0);
        chk("R1 cpu_accept", cpu_accept, 0);
        chk("R1 idma_req", idma_req, 0);
        chk("R1 hs_trig", hs_trig, 0);

        // R2 flag set with enable off; R3 no request then
        fire();
        rd(0, d);
        chk("R2 flag", d[0], 1);
        chk("R3 irq with en=0", irq_req, 0);
        step();

        // R3 enable / disable, R4 clear
        wr(0, 8'h02);
        chk("R3 irq with en=1", irq_req, 1);
        wr(0, 8'h00);
        chk("R3 irq drops on disable", irq_req, 0);
        rd(0, d);
        chk("R4 write 0 keeps flag", d[0], 1);
        wr(0, 8'h02);
        chk("R3 irq back", irq_req, 1);
        wr(0, 8'h03);
        rd(0, d);
        chk("R4 w1c clears", d[0], 0);
        chk("R3 irq after clear", irq_req, 0);

        // R4 event wins over same-cycle clear
        evt_done = 1'b1;
        wr(0, 8'h03);
        evt_done = 1'b0;
        rd(0, d);
        chk("R4 event wins", d[0], 1);
        step();

        // R5 priority field
        for (int p = 0; p < 8; p++) begin
            wr(0, 8'((p << 4) | 2));
            rd(0, d);
            chk("R5 readback", d[6:4], p);
            chk("R5 irq_level", irq_level, p);
        end

        // R6 acceptance sweep, flag held at 1
        for (int en = 0; en < 2; en++)
            for (int p = 0; p < 8; p++) begin
                wr(0, 8'((p << 4) | (en << 1)));
                for (int ie = 0; ie < 2; ie++)
                    for (int il = 0; il < 8; il++)
                        for (int hp = 0; hp < 2; hp++) begin
                            cpu_ie = 1'(ie); cpu_il = 3'(il); hi_pend = 1'(hp);
                            #0.5;
                            chk("R6 accept", cpu_accept,
                                (en == 1 && ie == 1 && hp == 0 && il < p) ? 1 : 0);
                        end
            end
        cpu_ie = 0; cpu_il = 0; hi_pend = 0;

        // R7 DMA path armed
        wr(0, 8'h73);
        wr(1, 8'h03);
        fire();
        chk("R7 idma_req pulse", idma_req, 1);
        chk("R7 idma_chan", idma_chan, 27);
        rd(0, d);
        chk("R7 flag untouched", d[0], 0);
        chk("R7 no irq", irq_req, 0);
        step();
        chk("R7 pulse one cycle", idma_req, 0);
        // R7 only one arming bit each
        for (int b = 1; b < 3; b++) begin
            wr(1, 8'(b));
            fire();
            chk("R7 partial arm no req", idma_req, 0);
            rd(0, d);
            chk("R7 partial arm sets flag", d[0], 1);
            chk("R3 partial arm irq", irq_req, 1);
            step();
            wr(0, 8'h73);
        end

        // R8 completion pulse
        wr(1, 8'h03);
        dma_done = 1'b1; step(); dma_done = 1'b0;
        rd(0, d);
        chk("R8 done ignored", d[0], 0);
        chk("R8 no irq", irq_req, 0);
        wr(1, 8'h07);
        dma_done = 1'b1; step(); dma_done = 1'b0;
        rd(0, d);
        chk("R8 done sets flag", d[0], 1);
        chk("R8 irq after done", irq_req, 1);

        // R9 trigger selector sweep, DMA path off then on
        for (int m = 0; m < 2; m++) begin
            wr(1, m ? 8'h03 : 8'h00);
            wr(0, m ? 8'h00 : 8'h03);
            for (int c = 0; c < 16; c++) begin
                logic [3:0] s0, s1, s2, s3, exp;
                s0 = 4'(c); s1 = 4'(c + 5); s2 = 4'(c + 10); s3 = 4'(c + 15);
                wr(2, {s1, s0});
                wr(3, {s3, s2});
                rd(2, d);
                chk("R9 sel01 readback", d, {s1, s0});
                exp = {s3 == 4'hC, s2 == 4'hC, s1 == 4'hC, s0 == 4'hC};
                chk("R9 idle", hs_trig, 0);
                fire();
                chk("R9 trig", hs_trig, exp);
                step();
                chk("R9 trig one cycle", hs_trig, 0);
            end
        end

        // R10 held level gives one pulse
        wr(2, 8'hCC);
        wr(3, 8'hCC);
        wr(1, 8'h03);
        evt_done = 1'b1;
        step();
        chk("R10 first pulse hs", hs_trig, 15);
        chk("R10 first pulse idma", idma_req, 1);
        for (int k = 0; k < 3; k++) begin
            step();
            chk("R10 held hs", hs_trig, 0);
            chk("R10 held idma", idma_req, 0);
        end
        evt_done = 1'b0;
        step();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule